// File: doc/BRIEF.md
# Vertical Color-Key Tap Cleaner

This stage sits in front of a 3-tap vertical scaling filter. Each column it receives holds three pixels (top, center, bottom) and one color-key match bit per pixel; the match bits are computed upstream. Before the column reaches the filter arithmetic, the stage swaps key-matched pixels for nearby pixels that do not match. A sharply contrasting key color therefore never bleeds into the blended image. It reports whether the column as a whole must stay a key pixel, and it turns that into an alpha value.

Two rule sets are available. The outer-filter rules serve the filters on either side of the center. The center-filter rules serve the middle filter, where a key-matched center pixel wins outright. An enable input bypasses all substitution. One registered stage with valid/ready flow control holds the result, giving one cycle of latency.

Top module: `ckv_vtap_clean`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0.
- R2: With `enable` low, the three output pixels equal the three input pixels, `out_key` is 0 and `out_alpha` is all ones, whatever `key_hit` and `center_mode` hold.
- R3: Outer rules (`center_mode`=0, `enable`=1). If only the top pixel is key-matched (`key_hit`=3'b001; bit 0 top, bit 1 center, bit 2 bottom), top is replaced by center. If only the bottom pixel is key-matched (3'b100), bottom is replaced by center. `out_key` is 0 in both cases.
- R4: Outer rules. If only the center pixel is key-matched (3'b010), center is replaced by top and `out_key` is 0.
- R5: Outer rules. If exactly two pixels are key-matched, all three outputs carry the one unmatched input pixel and `out_key` is 0.
- R6: Outer rules. If all three pixels are key-matched, all three outputs carry the bottom input pixel and `out_key` is 1.
- R7: Center rules (`center_mode`=1, `enable`=1). If the center pixel is key-matched, all three outputs carry the center input pixel and `out_key` is 1, whatever the top and bottom flags hold.
- R8: Center rules. If the center pixel is not key-matched, a key-matched top or bottom pixel is replaced by center, an unmatched one passes unchanged, and `out_key` is 0.
- R9: With `enable` high and `key_hit`=3'b000, the pixels pass unchanged in either mode and `out_key` is 0.
- R10: Whenever `out_valid` is 1, `out_alpha` is 0 if `out_key` is 1 and all ones otherwise.
- R11: `in_ready` equals `!out_valid || out_ready`. A column accepted on an edge (`in_valid && in_ready`) appears at the outputs with `out_valid`=1 after that edge. While `out_valid && !out_ready`, the outputs hold their values on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | 1 = apply substitution, 0 = bypass |
| center_mode | input | 1 | 0 = outer-filter rules, 1 = center-filter rules |
| in_valid | input | 1 | Input column valid |
| in_ready | output | 1 | Stage can accept a column |
| key_hit | input | 3 | Key-match flags: bit 0 top, bit 1 center, bit 2 bottom |
| in_top | input | PIX_W | Top pixel, RGB |
| in_ctr | input | PIX_W | Center pixel, RGB |
| in_bot | input | PIX_W | Bottom pixel, RGB |
| out_valid | output | 1 | Output column valid |
| out_ready | input | 1 | Consumer accepts the output column |
| out_top | output | PIX_W | Cleaned top pixel |
| out_ctr | output | PIX_W | Cleaned center pixel |
| out_bot | output | PIX_W | Cleaned bottom pixel |
| out_key | output | 1 | Column result is a color-key pixel |
| out_alpha | output | ALPHA_W | Alpha: 0 for key results, all ones otherwise |

## Verification
The hardest situation to reach from the ports is a column accepted in the same cycle that a stalled result is released, while the key pattern and the mode both change from the previous column. A wrong hold or overwrite in the output register shows up only there. The stimulus keeps `in_valid` asserted back to back while `out_ready` toggles randomly, mostly high but often low. This produces long stalls, release-and-accept edges, and every key pattern under both rule sets and both enable settings. The reference model checks each consumed column in order, and it checks that held outputs stay frozen through every stall.

// File: rtl/ckv_pkg.sv
package ckv_pkg;

  localparam int NTAP = 3;

  // Which input tap feeds an output tap; values match tap indices.
  typedef enum logic [1:0] {
    TAP_TOP = 2'd0,
    TAP_CTR = 2'd1,
    TAP_BOT = 2'd2
  } tap_src_e;

  typedef struct packed {
    tap_src_e [NTAP-1:0] src;
    logic                is_key;
  } tap_plan_t;

  function automatic tap_plan_t plan_identity();
    tap_plan_t p;
    p.src[0] = TAP_TOP;
    p.src[1] = TAP_CTR;
    p.src[2] = TAP_BOT;
    p.is_key = 1'b0;
    return p;
  endfunction

  function automatic tap_plan_t plan_all(input tap_src_e s, input logic k);
    tap_plan_t p;
    for (int i = 0; i < NTAP; i++) p.src[i] = s;
    p.is_key = k;
    return p;
  endfunction

endpackage

// File: rtl/ckv_outer_plan.sv
module ckv_outer_plan
  import ckv_pkg::*;
(
  input  logic [NTAP-1:0] hit,
  output tap_plan_t       plan
);

  always_comb begin
    plan = plan_identity();
    unique case (hit)
      3'b000: plan = plan_identity();
      3'b001: plan.src[0] = TAP_CTR;               // top alone keyed
      3'b100: plan.src[2] = TAP_CTR;               // bottom alone keyed
      3'b010: plan.src[1] = TAP_TOP;               // center alone keyed
      3'b011: plan = plan_all(TAP_BOT, 1'b0);      // bottom survives
      3'b101: plan = plan_all(TAP_CTR, 1'b0);      // center survives
      3'b110: plan = plan_all(TAP_TOP, 1'b0);      // top survives
      3'b111: plan = plan_all(TAP_BOT, 1'b1);      // column is key
      default: plan = plan_identity();
    endcase
  end

endmodule

// File: rtl/ckv_center_plan.sv
module ckv_center_plan
  import ckv_pkg::*;
(
  input  logic [NTAP-1:0] hit,
  output tap_plan_t       plan
);

  always_comb begin
    if (hit[1]) begin
      plan = plan_all(TAP_CTR, 1'b1);
    end else begin
      plan        = plan_identity();
      plan.src[0] = hit[0] ? TAP_CTR : TAP_TOP;
      plan.src[2] = hit[2] ? TAP_CTR : TAP_BOT;
    end
  end

endmodule

// File: rtl/ckv_tap_mux.sv
module ckv_tap_mux
  import ckv_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic [NTAP-1:0][PIX_W-1:0] taps,
  input  tap_src_e [NTAP-1:0]        src,
  output logic [NTAP-1:0][PIX_W-1:0] picked
);

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    always_comb begin
      unique case (src[g])
        TAP_TOP: picked[g] = taps[0];
        TAP_CTR: picked[g] = taps[1];
        TAP_BOT: picked[g] = taps[2];
        default: picked[g] = taps[g];
      endcase
    end
  end

endmodule

// File: rtl/ckv_stage.sv
module ckv_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/ckv_vtap_clean.sv
module ckv_vtap_clean
  import ckv_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int ALPHA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               center_mode,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NTAP-1:0]    key_hit,
  input  logic [PIX_W-1:0]   in_top,
  input  logic [PIX_W-1:0]   in_ctr,
  input  logic [PIX_W-1:0]   in_bot,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIX_W-1:0]   out_top,
  output logic [PIX_W-1:0]   out_ctr,
  output logic [PIX_W-1:0]   out_bot,
  output logic               out_key,
  output logic [ALPHA_W-1:0] out_alpha
);

  localparam int PIXS_W = NTAP * PIX_W;
  localparam int DATA_W = ALPHA_W + 1 + PIXS_W;

  tap_plan_t outer_plan, center_plan, plan;
  logic [NTAP-1:0][PIX_W-1:0] taps, picked, held;
  logic [ALPHA_W-1:0] alpha_nxt;
  logic [DATA_W-1:0]  d_in, d_out;

  ckv_outer_plan  u_outer  (.hit(key_hit), .plan(outer_plan));
  ckv_center_plan u_center (.hit(key_hit), .plan(center_plan));

  always_comb begin
    if (!enable)         plan = plan_identity();
    else if (center_mode) plan = center_plan;
    else                 plan = outer_plan;
  end

  assign taps = {in_bot, in_ctr, in_top};

  ckv_tap_mux #(.PIX_W(PIX_W)) u_mux (
    .taps  (taps),
    .src   (plan.src),
    .picked(picked)
  );

  assign alpha_nxt = plan.is_key ? '0 : '1;
  assign d_in      = {alpha_nxt, plan.is_key, picked};

  ckv_stage #(.W(DATA_W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (d_in),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (d_out)
  );

  assign held      = d_out[PIXS_W-1:0];
  assign out_key   = d_out[PIXS_W];
  assign out_alpha = d_out[DATA_W-1 -: ALPHA_W];
  assign out_top   = held[0];
  assign out_ctr   = held[1];
  assign out_bot   = held[2];

endmodule

// File: rtl/ckv_vtap_clean_chk.sv
module ckv_vtap_clean_chk #(
  parameter int PIX_W   = 24,
  parameter int ALPHA_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               enable,
  input logic               center_mode,
  input logic               in_valid,
  input logic               in_ready,
  input logic [2:0]         key_hit,
  input logic [PIX_W-1:0]   in_top,
  input logic [PIX_W-1:0]   in_ctr,
  input logic [PIX_W-1:0]   in_bot,
  input logic               out_valid,
  input logic               out_ready,
  input logic [PIX_W-1:0]   out_top,
  input logic [PIX_W-1:0]   out_ctr,
  input logic [PIX_W-1:0]   out_bot,
  input logic               out_key,
  input logic [ALPHA_W-1:0] out_alpha
);

  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !out_valid); // R1

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (acc && !enable) |=> (out_top == $past(in_top) && out_ctr == $past(in_ctr)
                          && out_bot == $past(in_bot) && !out_key)); // R2

  AST_OUTER_ALL_KEY: assert property (@(posedge clk) disable iff (rst)
    (acc && enable && !center_mode && key_hit == 3'b111)
      |=> (out_key && out_top == $past(in_bot) && out_ctr == $past(in_bot))); // R6

  AST_CENTER_KEY_WINS: assert property (@(posedge clk) disable iff (rst)
    (acc && enable && center_mode && key_hit[1])
      |=> (out_key && out_top == $past(in_ctr) && out_bot == $past(in_ctr))); // R7

  AST_ALPHA_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_key ? (out_alpha == '0) : (out_alpha == '1))); // R10

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid); // R11

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_top) && $stable(out_ctr)
                                   && $stable(out_bot) && $stable(out_key))); // R11

endmodule

bind ckv_vtap_clean ckv_vtap_clean_chk #(.PIX_W(PIX_W), .ALPHA_W(ALPHA_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .center_mode(center_mode),
  .in_valid(in_valid), .in_ready(in_ready), .key_hit(key_hit),
  .in_top(in_top), .in_ctr(in_ctr), .in_bot(in_bot),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_top(out_top), .out_ctr(out_ctr), .out_bot(out_bot),
  .out_key(out_key), .out_alpha(out_alpha)
);

// File: tb/ckv_vtap_clean_test.sv
module ckv_vtap_clean_test;

  localparam int PW = 24;
  localparam int AW = 8;

  typedef struct {
    logic [PW-1:0] t, c, b;
    logic          k;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, center_mode = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [2:0] key_hit = 3'b000;
  logic [PW-1:0] in_top = '0, in_ctr = '0, in_bot = '0;
  logic in_ready, out_valid, out_key;
  logic [PW-1:0] out_top, out_ctr, out_bot;
  logic [AW-1:0] out_alpha;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  ckv_vtap_clean #(.PIX_W(PW), .ALPHA_W(AW)) uut (
    .clk(clk), .rst(rst), .enable(enable), .center_mode(center_mode),
    .in_valid(in_valid), .in_ready(in_ready), .key_hit(key_hit),
    .in_top(in_top), .in_ctr(in_ctr), .in_bot(in_bot),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_top(out_top), .out_ctr(out_ctr), .out_bot(out_bot),
    .out_key(out_key), .out_alpha(out_alpha)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference for one column.
  function automatic exp_t model(input logic en, input logic cm, input logic [2:0] h,
                                 input logic [PW-1:0] t, input logic [PW-1:0] c,
                                 input logic [PW-1:0] b);
    exp_t e;
    int n;
    logic [PW-1:0] keep;
    e.t = t; e.c = c; e.b = b; e.k = 1'b0;
    n = int'(h[0]) + int'(h[1]) + int'(h[2]);
    if (!en) begin
      e.tag = "R2";
    end else if (n == 0) begin
      e.tag = "R9";
    end else if (cm) begin
      if (h[1]) begin
        e.t = c; e.b = c; e.k = 1'b1; e.tag = "R7";
      end else begin
        if (h[0]) e.t = c;
        if (h[2]) e.b = c;
        e.tag = "R8";
      end
    end else if (n == 1) begin
      if (h[0]) begin e.t = c; e.tag = "R3"; end
      if (h[2]) begin e.b = c; e.tag = "R3"; end
      if (h[1]) begin e.c = t; e.tag = "R4"; end
    end else if (n == 2) begin
      keep = !h[0] ? t : (!h[1] ? c : b);
      e.t = keep; e.c = keep; e.b = keep; e.tag = "R5";
    end else begin
      e.t = b; e.c = b; e.b = b; e.k = 1'b1; e.tag = "R6";
    end
    return e;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Monitor: everything sampled on the falling edge.
  logic stalled = 1'b0;
  logic [PW-1:0] h_t, h_c, h_b;
  logic h_k;
  always @(negedge clk) begin
    if (rst) begin
      check(out_valid == 1'b0, "R1", "out_valid in reset", {23'd0, out_valid}, '0);
      stalled = 1'b0;
    end else begin
      check(in_ready == (!out_valid || out_ready), "R11", "in_ready",
            {23'd0, in_ready}, {23'd0, (!out_valid || out_ready)});
      if (stalled) begin
        check(out_valid && out_top == h_t && out_ctr == h_c && out_bot == h_b && out_key == h_k,
              "R11", "held column", out_top, h_t);
      end
      if (out_valid) begin
        check(out_alpha == (out_key ? 8'h00 : 8'hFF), "R10", "alpha",
              {16'd0, out_alpha}, out_key ? 24'h0 : 24'hFF);
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R11", "unexpected output", out_top, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_top == e.t, e.tag, "top", out_top, e.t);
          check(out_ctr == e.c, e.tag, "center", out_ctr, e.c);
          check(out_bot == e.b, e.tag, "bottom", out_bot, e.b);
          check(out_key == e.k, e.tag, "key flag", {23'd0, out_key}, {23'd0, e.k});
        end
      end
      stalled = out_valid && !out_ready;
      h_t = out_top; h_c = out_ctr; h_b = out_bot; h_k = out_key;
      if (in_valid && in_ready)
        q.push_back(model(enable, center_mode, key_hit, in_top, in_ctr, in_bot));
    end
  end

  task automatic send(input logic en, input logic cm, input logic [2:0] h,
                      input logic [PW-1:0] t, input logic [PW-1:0] c, input logic [PW-1:0] b);
    @(posedge clk); #1;
    enable = en; center_mode = cm; key_hit = h;
    in_top = t; in_ctr = c; in_bot = b; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
  endtask

  initial begin
    wait (!rst);
    forever begin
      @(posedge clk); #1;
      out_ready = ($urandom % 4) != 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1: no output on the first cycle out of reset
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", {23'd0, out_valid}, '0);
    // Directed: every key pattern in both modes with substitution on, then bypass.
    for (int m = 0; m < 2; m++) begin
      for (int h = 0; h < 8; h++) begin
        send(1'b1, m[0], h[2:0], 24'hA00000 + 24'(h), 24'h0B0000 + 24'(h), 24'h00C000 + 24'(h));
      end
    end
    for (int h = 0; h < 8; h++) send(1'b0, h[0], h[2:0], 24'h111111, 24'h222222, 24'h333333);
    // Random traffic under random backpressure.
    for (int i = 0; i < 600; i++) begin
      send(($urandom % 5) != 0, $urandom % 2, 3'($urandom), 24'($urandom), 24'($urandom),
           24'($urandom));
    end
    @(posedge clk); #1 in_valid = 1'b0;
    while (q.size() != 0 || out_valid) @(posedge clk);
    repeat (2) @(posedge clk);
    summary();
  end

endmodule